// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the register file of one bus-master disk DMA channel as a byte-wide host bus sees it. Software uses it to load a 32-bit pointer to the descriptor table, choose the transfer direction, and start or stop the engine. Afterwards it reads a status byte to learn how the transfer ended. The DMA engine itself sits next to the block. It receives the start bit, the direction bit and the table pointer. It sends back single-cycle pulses when a transfer completes, when it hits an error, and when the device raises its interrupt.

The status byte holds three kinds of bit. The activity bit is read-only and the hardware owns it. The error and interrupt flags are sticky: the engine sets them and software clears them by writing ones. The two per-drive capability flags are plain storage. The interrupt flag also drives an interrupt line to the host. A finished transfer counts as good only when the low three status bits read 100b: interrupt seen, no error, engine idle.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every readable byte at offsets 0, 2 and 4 to 7 reads 0x00, and irq_o, run_o and to_mem_o are low.
- R2: Offset 0 is the command byte. Bit 0 is start and bit 3 is direction (1 = device data goes to memory). The other bits read 0. Writes take effect on the next clock. run_o follows bit 0 and to_mem_o follows bit 3.
- R3: Offsets 1 and 3 are reserved for vendor use. They read 0x00 and writes to them change no state.
- R4: Status bit 0 (active) sets in the cycle after a command write turns start from 0 to 1. A write that leaves start at 1 does not set it again.
- R5: Active clears after an eng_done_i pulse, after an eng_err_i pulse, or after a command write turns start from 1 to 0.
- R6: Status bit 1 (error) sets on eng_err_i. Writing a 1 to bit 1 at offset 2 clears it, and writing a 0 leaves it unchanged.
- R7: Status bit 2 (interrupt) sets on dev_irq_i and clears on a write of 1 to bit 2. irq_o is high exactly while this bit is set.
- R8: If an engine event and a clearing write land in the same cycle, the event wins and the flag stays set.
- R9: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0, and writes to bit 0 are ignored.
- R10: Offsets 4 to 7 hold the descriptor-table pointer, least significant byte first. Its low two bits always read 0, and table_base_o presents the whole pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Byte offset within the window |
| reg_we_i | input | 1 | Write strobe for the addressed byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed byte, combinational |
| eng_done_i | input | 1 | Engine pulse: transfer finished |
| eng_err_i | input | 1 | Engine pulse: transfer error |
| dev_irq_i | input | 1 | Device interrupt event |
| run_o | output | 1 | Start bit to the engine |
| to_mem_o | output | 1 | Direction to the engine: 1 = device to memory |
| table_base_o | output | 32 | Descriptor-table pointer |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The hardest case to reach from the ports is an engine event that arrives in the same clock as a write-one-to-clear of the flag it sets. The bench has a combined task that drives dev_irq_i together with the status write inside one cycle, and then reads the flag back. A second case needs care: a start write that repeats 1 after the engine has already finished. To reach it, the bench lets a done pulse end the transfer first, rewrites start as 1, and checks that active stays low.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned OFF_CMD  = 0;
  localparam int unsigned OFF_STAT = 2;
  localparam int unsigned OFF_PTR  = 4;

  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_DIR   = 3;

  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;
  localparam int unsigned ST_CAP0 = 5;
  localparam int unsigned ST_CAP1 = 6;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic start_bit_i,
  input  logic dir_bit_i,
  output logic start_o,
  output logic dir_o,
  output logic rise_o,
  output logic fall_o
);
  logic start_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (we_i) begin
      start_q <= start_bit_i;
      dir_q   <= dir_bit_i;
    end
  end

  assign start_o = start_q;
  assign dir_o   = dir_q;
  assign rise_o  = we_i &  start_bit_i & ~start_q;
  assign fall_o  = we_i & ~start_bit_i &  start_q;

  p_start_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (start_o == $past(start_bit_i)) && (dir_o == $past(dir_bit_i)));
  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(start_o) && $stable(dir_o));
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status
  import bmdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       err_clr_i,
  input  logic       irq_clr_i,
  input  logic [1:0] cap_i,
  input  logic       start_rise_i,
  input  logic       start_fall_i,
  input  logic       done_i,
  input  logic       err_i,
  input  logic       irq_ev_i,
  output logic [7:0] stat_o
);
  logic act_q, err_q, irq_q;
  logic [1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= 2'b00;
    end else begin
      // a fresh start outranks a stop condition in the same cycle
      if (start_rise_i)                          act_q <= 1'b1;
      else if (done_i || err_i || start_fall_i)  act_q <= 1'b0;
      // engine events outrank software clears
      if (err_i)                   err_q <= 1'b1;
      else if (we_i && err_clr_i)  err_q <= 1'b0;
      if (irq_ev_i)                irq_q <= 1'b1;
      else if (we_i && irq_clr_i)  irq_q <= 1'b0;
      if (we_i)                    cap_q <= cap_i;
    end
  end

  always_comb begin
    stat_o          = 8'h00;
    stat_o[ST_ACT]  = act_q;
    stat_o[ST_ERR]  = err_q;
    stat_o[ST_IRQ]  = irq_q;
    stat_o[ST_CAP0] = cap_q[0];
    stat_o[ST_CAP1] = cap_q[1];
  end

  p_act_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise_i |=> stat_o[ST_ACT]);
  p_act_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || err_i || start_fall_i) && !start_rise_i |=> !stat_o[ST_ACT]);
  p_err_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_o[ST_ERR]);
  p_err_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && err_clr_i && !err_i |=> !stat_o[ST_ERR]);
  p_irq_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ev_i && we_i && irq_clr_i |=> stat_o[ST_IRQ]);
  p_cap_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> {stat_o[ST_CAP1], stat_o[ST_CAP0]} == $past(cap_i));
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned ALIGN_BITS = 2,
  localparam int unsigned NB        = PTR_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    sel_i,
  input  logic [7:0]       wdata_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [7:0] LOW_MASK = 8'hFF << ALIGN_BITS;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [7:0] MASK = (b == 0) ? LOW_MASK : 8'hFF;
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       byte_q <= 8'h00;
      else if (sel_i[b]) byte_q <= wdata_i & MASK;
    end
    assign ptr_o[b*8 +: 8] = byte_q;
  end

  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|sel_i) |=> $stable(ptr_o));
  p_ptr_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[NB-1] |=> ptr_o[PTR_W-1 -: 8] == $past(wdata_i));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              dev_irq_i,
  output logic              run_o,
  output logic              to_mem_o,
  output logic [PTR_W-1:0]  table_base_o,
  output logic              irq_o
);
  localparam int unsigned NB   = PTR_W / 8;
  localparam int unsigned PB_W = (NB > 1) ? $clog2(NB) : 1;

  logic cmd_we, stat_we, rise, fall;
  logic [NB-1:0] ptr_sel;
  logic [7:0] stat;

  assign cmd_we  = reg_we_i && (reg_addr_i == ADDR_W'(OFF_CMD));
  assign stat_we = reg_we_i && (reg_addr_i == ADDR_W'(OFF_STAT));

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign ptr_sel[b] = reg_we_i && (reg_addr_i == ADDR_W'(OFF_PTR + b));
  end

  bmdma_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cmd_we),
    .start_bit_i (reg_wdata_i[CMD_START]),
    .dir_bit_i   (reg_wdata_i[CMD_DIR]),
    .start_o     (run_o),
    .dir_o       (to_mem_o),
    .rise_o      (rise),
    .fall_o      (fall)
  );

  bmdma_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (stat_we),
    .err_clr_i    (reg_wdata_i[ST_ERR]),
    .irq_clr_i    (reg_wdata_i[ST_IRQ]),
    .cap_i        ({reg_wdata_i[ST_CAP1], reg_wdata_i[ST_CAP0]}),
    .start_rise_i (rise),
    .start_fall_i (fall),
    .done_i       (eng_done_i),
    .err_i        (eng_err_i),
    .irq_ev_i     (dev_irq_i),
    .stat_o       (stat)
  );

  bmdma_ptr #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (ptr_sel),
    .wdata_i (reg_wdata_i),
    .ptr_o   (table_base_o)
  );

  assign irq_o = stat[ST_IRQ];

  logic [PB_W-1:0] pidx;
  assign pidx = PB_W'(reg_addr_i - ADDR_W'(OFF_PTR));

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == ADDR_W'(OFF_CMD)) begin
      reg_rdata_o[CMD_START] = run_o;
      reg_rdata_o[CMD_DIR]   = to_mem_o;
    end else if (reg_addr_i == ADDR_W'(OFF_STAT)) begin
      reg_rdata_o = stat;
    end else if (32'(reg_addr_i) >= OFF_PTR && 32'(reg_addr_i) < OFF_PTR + NB) begin
      reg_rdata_o = table_base_o[32'(pidx)*8 +: 8];
    end
  end

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(dev_irq_i));
  p_vendor_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == ADDR_W'(1) || reg_addr_i == ADDR_W'(3))
      |=> $stable(run_o) && $stable(to_mem_o) && $stable(table_base_o) && $stable(stat));
endmodule

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic eng_done_i = 1'b0, eng_err_i = 1'b0, dev_irq_i = 1'b0;
  logic run_o, to_mem_o, irq_o;
  logic [31:0] table_base_o;

  always #10 clk_i = ~clk_i;

  bmdma_regs dut (.*);

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 run, 3 dir, 4 base
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  logic chk_req = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // monitor: pop and compare on the falling edge
  always @(negedge clk_i) begin
    if (chk_req && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {24'h0, reg_rdata_o};
        1: act = {31'h0, irq_o};
        2: act = {31'h0, run_o};
        3: act = {31'h0, to_mem_o};
        default: act = table_base_o;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int kind, input logic [2:0] a, input logic [31:0] e, input string req);
    item_t it;
    @(posedge clk_i); #1;
    reg_addr_i = a;
    it.kind = kind; it.exp = e; it.req = req;
    sb.push_back(it);
    chk_req = 1'b1;
    @(posedge clk_i); #1;
    chk_req = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
    expect_val(0, a, {24'h0, e}, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk_i); #1;
    case (which)
      0: eng_done_i = 1'b1;
      1: eng_err_i = 1'b1;
      default: dev_irq_i = 1'b1;
    endcase
    @(posedge clk_i); #1;
    eng_done_i = 1'b0; eng_err_i = 1'b0; dev_irq_i = 1'b0;
  endtask

  task automatic irq_and_clear();
    @(posedge clk_i); #1;
    dev_irq_i = 1'b1;
    reg_addr_i = 3'd2; reg_wdata_i = 8'h04; reg_we_i = 1'b1;
    @(posedge clk_i); #1;
    dev_irq_i = 1'b0; reg_we_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(3'd0, 8'h00, "R1 cmd");
    rd(3'd2, 8'h00, "R1 status");
    for (int i = 4; i < 8; i++) rd(3'(i), 8'h00, "R1 ptr");
    expect_val(1, 3'd0, 0, "R1 irq_o");
    expect_val(2, 3'd0, 0, "R1 run_o");
    // R2 command byte, R4 active rise
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h09, "R2 cmd readback");
    expect_val(2, 3'd0, 1, "R2 run_o");
    expect_val(3, 3'd0, 1, "R2 to_mem_o");
    rd(3'd2, 8'h01, "R4 active after start");
    // R3 vendor offsets
    wr(3'd1, 8'hAA);
    wr(3'd3, 8'h55);
    rd(3'd1, 8'h00, "R3 offset1");
    rd(3'd3, 8'h00, "R3 offset3");
    rd(3'd0, 8'h09, "R3 cmd unchanged");
    rd(3'd2, 8'h01, "R3 status unchanged");
    // R5 done clears, R4 no re-arm while start held
    pulse(0);
    rd(3'd2, 8'h00, "R5 done clears active");
    wr(3'd0, 8'h09);
    rd(3'd2, 8'h00, "R4 start held no re-arm");
    wr(3'd0, 8'h00);
    expect_val(2, 3'd0, 0, "R2 run_o low");
    wr(3'd0, 8'h01);
    rd(3'd2, 8'h01, "R4 re-arm");
    rd(3'd0, 8'h01, "R2 dir cleared");
    wr(3'd0, 8'h00);
    rd(3'd2, 8'h00, "R5 stop clears active");
    // R6 error
    wr(3'd0, 8'h01);
    pulse(1);
    rd(3'd2, 8'h02, "R6 error set, R5 active cleared");
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h02, "R6 write 0 keeps error");
    wr(3'd2, 8'h02);
    rd(3'd2, 8'h00, "R6 w1c error");
    // R7 interrupt, good completion pattern
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h01);
    pulse(2);
    pulse(0);
    rd(3'd2, 8'h04, "R7 good completion 100b");
    expect_val(1, 3'd0, 1, "R7 irq_o high");
    wr(3'd2, 8'h04);
    rd(3'd2, 8'h00, "R7 w1c interrupt");
    expect_val(1, 3'd0, 0, "R7 irq_o low");
    // R8 event beats clear
    irq_and_clear();
    rd(3'd2, 8'h04, "R8 event wins");
    // R9 capability and reserved bits
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h60, "R9 caps set, reserved zero");
    wr(3'd2, 8'h20);
    rd(3'd2, 8'h20, "R9 drive0 only");
    // R10 pointer
    wr(3'd4, 8'h13);
    wr(3'd5, 8'h57);
    wr(3'd6, 8'h9B);
    wr(3'd7, 8'hDF);
    rd(3'd4, 8'h10, "R10 low bits zero");
    rd(3'd5, 8'h57, "R10 byte1");
    rd(3'd6, 8'h9B, "R10 byte2");
    rd(3'd7, 8'hDF, "R10 byte3");
    expect_val(4, 3'd0, 32'hDF9B5710, "R10 table_base_o");
    repeat (3) @(posedge clk_i);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule